// File: doc/BRIEF.md
# Break and Abort Status Detector

This block produces the receiver's break/abort status bit. It watches the sampled receive bit stream and a received-character interface. The meaning of the bit follows the protocol mode. In asynchronous mode the bit reports a line break. A break starts when a character of all zeros arrives with a framing error, and it lasts until the line returns to 1. In SDLC mode the bit reports an abort, which is a run of seven or more 1 bits. Entering abort also asks the receiver to go back to hunting for a flag. In the other synchronous modes the bit is held at 0.

Three one-cycle pulses come out beside the status bit. The first marks every change of the status, for the interrupt latching logic. The second requests hunt when an abort begins. The third tags the null character that is left in the receive FIFO when a break ends, so that software can drop it. Character assembly happens upstream; this block only consumes its completed-character indication.

Top module: `brk_abort_detect`

## Requirements
- R1: While reset is low and in the first cycle after it, `brkStatus`, `statusEdge`, `huntReq` and `nullTag` are all 0.
- R2: In asynchronous mode (`modeSel` = 2'b00), `brkStatus` becomes 1 one cycle after a clock edge at which `charDone` is high, `charData` is all zeros and `charFrameErr` is high. A nonzero character, or a zero character without a framing error, does not set it.
- R3: In asynchronous mode, once set, `brkStatus` stays 1 while only valid 0 bits arrive. It returns to 0 one cycle after an edge with `rxBitValid` high and `rxBit` = 1.
- R4: `nullTag` is a one-cycle pulse, high exactly in the first cycle in which an asynchronous break has cleared through a received 1 bit.
- R5: In SDLC mode (`modeSel` = 2'b01), `brkStatus` becomes 1 in the cycle after the seventh consecutive valid 1 bit is sampled. Six or fewer consecutive 1 bits leave it at 0.
- R6: In SDLC mode the count of consecutive 1 bits saturates at seven and restarts on any valid 0 bit. Abort stays set through further 1 bits and clears one cycle after a valid 0 bit.
- R7: `huntReq` is a one-cycle pulse, high exactly in the first cycle of each SDLC abort, and at no other time.
- R8: With `modeSel` = 2'b10 or 2'b11 (other synchronous modes), `brkStatus` is 0 one cycle later, whatever its earlier value and whatever the other inputs are.
- R9: `statusEdge` is high for exactly one cycle in each cycle in which `brkStatus` differs from its value in the previous cycle.
- R10: A bit with `rxBitValid` low has no effect, and in SDLC mode the character inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | 00 async, 01 SDLC, 10/11 other synchronous |
| rxBit | input | 1 | Sampled receive bit |
| rxBitValid | input | 1 | Strobe qualifying rxBit |
| charDone | input | 1 | A received character is complete |
| charData | input | 8 | Data of the completed character |
| charFrameErr | input | 1 | Framing error of the completed character |
| brkStatus | output | 1 | Break (async) or abort (SDLC) status |
| statusEdge | output | 1 | Pulse on each change of brkStatus |
| huntReq | output | 1 | Pulse requesting hunt at the start of an abort |
| nullTag | output | 1 | Pulse tagging the null character left when a break ends |

## Verification
The ones-run counter and the status register are the only state. If the counter is corrupted, the abort shows up one bit too early or too late, on the 6th or 8th valid 1 bit, or a broken run aborts anyway. Any of these is visible in `brkStatus` and `huntReq` one cycle after the offending bit. A status register that keeps a stale value when the mode changes shows up one cycle after the mode change. A status bit that does not clear shows up one cycle after the first clearing bit, and the missing `nullTag` or `statusEdge` pulse shows up in that same cycle.

// File: rtl/brk_abort_pkg.sv
package brk_abort_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'b00,
    MODE_SDLC   = 2'b01,
    MODE_SYNC_A = 2'b10,
    MODE_SYNC_B = 2'b11
  } lineMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrRun;
    logic countEn;
  } dpCtrl_t;

  // datapath -> control events
  typedef struct packed {
    logic oneSeen;
    logic zeroSeen;
    logic runHit;
    logic nullChar;
  } dpEvt_t;

endpackage

// File: rtl/brk_abort_data.sv
module brk_abort_data
  import brk_abort_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RUN_LEN = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              rxBit,
  input  logic              rxBitValid,
  input  logic              charDone,
  input  logic [DATA_W-1:0] charData,
  input  logic              charFrameErr,
  output dpEvt_t            evt
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] RUN_PRE = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runNext;

  always_comb begin
    runNext = runCnt;
    if (ctl.clrRun) begin
      runNext = '0;
    end else if (ctl.countEn) begin
      if (!rxBit)                runNext = '0;
      else if (runCnt != RUN_MAX) runNext = runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else       runCnt <= runNext;
  end

  always_comb begin
    evt.oneSeen  = rxBitValid && rxBit;
    evt.zeroSeen = rxBitValid && !rxBit;
    evt.runHit   = ctl.countEn && rxBit && (runCnt >= RUN_PRE);
    evt.nullChar = charDone && charFrameErr && (charData == '0);
  end

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !ctl.clrRun && !rxBit) |=> (runCnt == '0)); // R6

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !ctl.clrRun && rxBit && runCnt == RUN_MAX) |=> (runCnt == RUN_MAX)); // R6

endmodule

// File: rtl/brk_abort_ctrl.sv
module brk_abort_ctrl
  import brk_abort_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       rxBitValid,
  input  dpEvt_t     evt,
  output dpCtrl_t    ctl,
  output logic       brkStatus,
  output logic       statusEdge,
  output logic       huntReq,
  output logic       nullTag
);

  lineMode_e mode;
  logic      statusQ;
  logic      statusNext;
  logic      abortStart;
  logic      breakEnd;

  assign mode = lineMode_e'(modeSel);

  always_comb begin
    ctl.clrRun  = (mode != MODE_SDLC);
    ctl.countEn = (mode == MODE_SDLC) && rxBitValid;
  end

  always_comb begin
    statusNext = 1'b0;
    abortStart = 1'b0;
    breakEnd   = 1'b0;
    unique case (mode)
      MODE_ASYNC: begin
        if (statusQ) begin
          breakEnd   = evt.oneSeen;
          statusNext = !evt.oneSeen;
        end else begin
          statusNext = evt.nullChar;
        end
      end
      MODE_SDLC: begin
        if (statusQ) begin
          statusNext = !evt.zeroSeen;
        end else begin
          abortStart = evt.runHit;
          statusNext = evt.runHit;
        end
      end
      default: statusNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ    <= 1'b0;
      statusEdge <= 1'b0;
      huntReq    <= 1'b0;
      nullTag    <= 1'b0;
    end else begin
      statusQ    <= statusNext;
      statusEdge <= statusNext ^ statusQ;
      huntReq    <= abortStart;
      nullTag    <= breakEnd;
    end
  end

  assign brkStatus = statusQ;

  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] |=> !brkStatus); // R8

  AST_EDGE_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(brkStatus) || $fell(brkStatus)) |-> statusEdge); // R9

  AST_HUNT_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    huntReq |-> $rose(brkStatus)); // R7

  AST_NULL_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    nullTag |-> $fell(brkStatus)); // R4

  AST_ASYNC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && brkStatus && rxBitValid && evt.oneSeen) |=> !brkStatus); // R3

endmodule

// File: rtl/brk_abort_detect.sv
module brk_abort_detect
  import brk_abort_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RUN_LEN = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              rxBit,
  input  logic              rxBitValid,
  input  logic              charDone,
  input  logic [DATA_W-1:0] charData,
  input  logic              charFrameErr,
  output logic              brkStatus,
  output logic              statusEdge,
  output logic              huntReq,
  output logic              nullTag
);

  dpCtrl_t ctl;
  dpEvt_t  evt;

  brk_abort_data #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit), .rxBitValid(rxBitValid),
    .charDone(charDone), .charData(charData), .charFrameErr(charFrameErr), .evt(evt)
  );

  brk_abort_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .rxBitValid(rxBitValid), .evt(evt),
    .ctl(ctl), .brkStatus(brkStatus), .statusEdge(statusEdge), .huntReq(huntReq),
    .nullTag(nullTag)
  );

endmodule

// File: tb/brk_abort_detect_test.sv
module brk_abort_detect_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       rxBit = 1'b1;
  logic       rxBitValid = 1'b0;
  logic       charDone = 1'b0;
  logic [7:0] charData = 8'h00;
  logic       charFrameErr = 1'b0;
  logic       brkStatus, statusEdge, huntReq, nullTag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic mStat = 1'b0;
  int   mRun = 0;
  logic eEdge = 1'b0, eHunt = 1'b0, eNull = 1'b0;

  always #5 clk = ~clk;

  brk_abort_detect uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .rxBit(rxBit), .rxBitValid(rxBitValid),
    .charDone(charDone), .charData(charData), .charFrameErr(charFrameErr),
    .brkStatus(brkStatus), .statusEdge(statusEdge), .huntReq(huntReq), .nullTag(nullTag)
  );

  task automatic chk(input logic act, input logic exp, input string msg);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", msg, act, exp, $time);
    end
  endtask

  function automatic void modelStep(input logic [1:0] m, input logic v, input logic b,
                                    input logic cd, input logic [7:0] d, input logic fe);
    logic prev;
    prev = mStat;
    if (m == 2'b00) begin
      mRun = 0;
      if (mStat) begin
        if (v && b) mStat = 1'b0;
      end else if (cd && fe && d == 8'h00) mStat = 1'b1;
    end else if (m == 2'b01) begin
      if (v) begin
        if (b) begin
          if (mRun < 7) mRun = mRun + 1;
          if (mRun == 7) mStat = 1'b1;
        end else begin
          mRun = 0;
          mStat = 1'b0;
        end
      end
    end else begin
      mRun = 0;
      mStat = 1'b0;
    end
    eEdge = prev != mStat;
    eHunt = !prev && mStat && m == 2'b01;
    eNull = prev && !mStat && m == 2'b00;
  endfunction

  task automatic cyc(input logic [1:0] m, input logic v, input logic b, input logic cd,
                     input logic [7:0] d, input logic fe, input string tag);
    modeSel = m; rxBitValid = v; rxBit = b; charDone = cd; charData = d; charFrameErr = fe;
    @(posedge clk);
    modelStep(m, v, b, cd, d, fe);
    @(negedge clk);
    chk(brkStatus,  mStat, tag);
    chk(statusEdge, eEdge, "R9 statusEdge");
    chk(huntReq,    eHunt, "R7 huntReq");
    chk(nullTag,    eNull, "R4 nullTag");
  endtask

  task automatic bitIn(input logic [1:0] m, input logic b, input string tag);
    cyc(m, 1'b1, b, 1'b0, 8'h00, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(brkStatus, 1'b0, "R1 status in reset");
    chk(statusEdge | huntReq | nullTag, 1'b0, "R1 pulses in reset");
    rstN = 1'b1;
    cyc(2'b00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R1 after reset");

    // R2: non-qualifying characters
    cyc(2'b00, 1'b0, 1'b0, 1'b1, 8'h01, 1'b1, "R2 nonzero char with framing error");
    cyc(2'b00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R2 null char without framing error");
    chk(brkStatus, 1'b0, "R2 no break set");
    cyc(2'b00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R2 break set");
    chk(brkStatus, 1'b1, "R2 break set directed");
    // R3 hold on zeros, R10 invalid one ignored
    bitIn(2'b00, 1'b0, "R3 hold on zero");
    bitIn(2'b00, 1'b0, "R3 hold on zero");
    cyc(2'b00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R10 invalid one ignored");
    chk(brkStatus, 1'b1, "R10 status kept");
    bitIn(2'b00, 1'b1, "R3 clear on one");
    chk(brkStatus, 1'b0, "R3 cleared directed");
    chk(nullTag, 1'b1, "R4 null tag directed");
    cyc(2'b00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R4 tag one cycle");
    chk(nullTag, 1'b0, "R4 tag gone");

    // R5 / R6 / R7 SDLC
    repeat (6) bitIn(2'b01, 1'b1, "R5 six ones no abort");
    chk(brkStatus, 1'b0, "R5 no abort after six");
    cyc(2'b01, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, "R5 seventh one aborts");
    chk(brkStatus, 1'b1, "R5 abort directed");
    chk(huntReq, 1'b1, "R7 hunt directed");
    repeat (5) bitIn(2'b01, 1'b1, "R6 saturated run keeps abort");
    chk(huntReq, 1'b0, "R7 no second hunt");
    bitIn(2'b01, 1'b0, "R6 zero clears abort");
    chk(brkStatus, 1'b0, "R6 cleared directed");
    repeat (6) bitIn(2'b01, 1'b1, "R6 run of six");
    bitIn(2'b01, 1'b0, "R6 run broken");
    repeat (6) bitIn(2'b01, 1'b1, "R6 second run of six");
    cyc(2'b01, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R10 char ignored in SDLC");
    chk(brkStatus, 1'b0, "R6 broken run no abort");
    bitIn(2'b01, 1'b1, "R5 seventh after restart");
    chk(brkStatus, 1'b1, "R5 abort after restart");

    // R8 other sync modes force zero
    bitIn(2'b10, 1'b1, "R8 sync forces zero");
    chk(brkStatus, 1'b0, "R8 forced directed");
    cyc(2'b11, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, "R8 sync ignores break char");
    chk(brkStatus, 1'b0, "R8 stays zero");

    // random phase
    begin
      logic [1:0] m;
      m = 2'b00;
      for (int i = 0; i < 4000; i++) begin
        logic v, b, cd, fe;
        logic [7:0] d;
        if ($urandom % 60 == 0) m = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'($urandom % 2);
        v  = ($urandom % 4) != 0;
        b  = (m == 2'b01) ? (($urandom % 9) != 0) : (($urandom % 3) == 0);
        cd = ($urandom % 5) == 0;
        d  = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
        fe = ($urandom % 2) == 0;
        cyc(m, v, b, cd, d, fe, "R2/R3/R5/R6/R8 random status");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule